// File: doc/BRIEF.md
# Down-Counting PWM Generator

This block produces a pulse-width-modulated output from a 24-bit periodic down counter. The low 16 bits are the main count and the upper byte is a prescaler extension that acts as the top byte of the count. Software writes a reload value, which sets the period, and a compare value, which sets the duty point. The output is high in the early part of each period and drops once the counter reaches the compare value. An inversion bit and a force-high-at-timeout option shape the waveform.

A one-cycle trigger pulse can be emitted at every timeout, for example to start a converter. An edge-event interrupt can be raised on rising, falling or both edges of the output. It has a sticky status bit, a write-one-to-clear action and its own mask. The PWM function runs only when three mode fields together select it.

Software uses a flat register port. Writes take effect at the clock edge on which the write strobe is high, and reads return data combinationally from the addressed register. The word map is: 0 mode, 1 control, 2 reload, 3 compare, 4 interrupt mask, 5 interrupt status, 6 live count (read-only).

Top module: `dcpwm_top`

## Requirements
- R1: The counter runs only when mode bit 3 is 1, mode bit 2 is 0, mode bits [1:0] equal 2 and control bit 0 (enable) is 1. Otherwise the count holds and the uninverted output level is 0.
- R2: While running, the count steps down by one each cycle. At the cycle after it reaches 0 it holds the full 24-bit reload value, so one period is reload+1 cycles. The count reads back at word 6.
- R3: While running, the uninverted level is 1 when count > compare and 0 otherwise. The output pin shows that level one cycle later.
- R4: A compare value greater than or equal to the reload value gives a constant-high uninverted level. A compare value of 0 gives exactly one low cycle per period.
- R5: When mode bit 4 is 1, the uninverted level is also 1 in the cycle where the count is 0.
- R6: Control bit 1 inverts the output pin when it is 1 and leaves it unchanged when it is 0.
- R7: A write to the reload word loads count bits [15:0] from the written data at that edge. Count bits [23:16] are loaded too when mode bit 6 is 0. When mode bit 6 is 1 they keep their value until the next timeout reload.
- R8: When control bit 2 is 1, the trigger pin pulses high for one cycle after each timeout. When control bit 2 is 0 it stays low.
- R9: When mode bit 5 is 1, an output edge chosen by control bits [4:3] sets status bit 0. The codes are 0 for rising, 1 for falling, 3 for both, and 2 for none. With mode bit 5 at 0 no edge sets it.
- R10: Writing 1 to status bit 0 clears it. The interrupt pin equals status bit 0 ANDed with mask bit 0.
- R11: After reset the output, trigger and interrupt pins are 0 and the count reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWdata | input | 32 | Write data |
| rdData | output | 32 | Read data for regAddr |
| pwmOut | output | 1 | PWM output pin |
| trigOut | output | 1 | One-cycle trigger at timeout |
| irqOut | output | 1 | Masked edge-event interrupt |

## Verification
The hardest case to reach is the deferred prescaler reload. It only shows when the upper count byte already holds a nonzero value, a new reload is written with the defer bit set, and the counter then reaches a timeout within a bench-sized window. The bench first loads a nonzero upper byte with deferral off. It then writes a deferred reload and reads back the kept byte. Next it sets up a small count with a zero upper byte, writes a deferred reload whose upper byte is nonzero, enables the counter and reads the count right after the first timeout. The edge-event tests also clear the status only after the counter is disabled, so that the falling edge this causes cannot set the status again.

// File: rtl/dcpwm_pkg.sv
package dcpwm_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE  = 3'd0,
    A_CTRL  = 3'd1,
    A_LOAD  = 3'd2,
    A_MATCH = 3'd3,
    A_MASK  = 3'd4,
    A_STAT  = 3'd5,
    A_COUNT = 3'd6
  } regAddrE;

  localparam logic [1:0] MODE_PERIODIC = 2'd2;
  localparam logic [1:0] EDGE_RISE = 2'd0;
  localparam logic [1:0] EDGE_FALL = 2'd1;
  localparam logic [1:0] EDGE_BOTH = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic loadWr;
    logic keepHigh;
    logic toHigh;
    logic invert;
    logic trigEn;
  } strobeT;
endpackage

// File: rtl/dcpwm_ctrl.sv
module dcpwm_ctrl
  import dcpwm_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [CNT_W-1:0]  countVal,
  input  logic              riseEv,
  input  logic              fallEv,
  output logic [DATA_W-1:0] rdData,
  output strobeT            stb,
  output logic [CNT_W-1:0]  loadReg,
  output logic [CNT_W-1:0]  matchReg,
  output logic              statusBit,
  output logic              maskBit,
  output logic              edgeIrqEn,
  output logic              irqOut
);
  logic [1:0] modeField;
  logic       captureSel, altSel, toHigh, deferHigh;
  logic       enable, invert, trigEn;
  logic [1:0] edgeSel;
  logic       pwmSelected, edgeHit;
  logic       unusedHi;

  assign unusedHi = ^regWdata[DATA_W-1:CNT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeField  <= '0;
      captureSel <= 1'b0;
      altSel     <= 1'b0;
      toHigh     <= 1'b0;
      edgeIrqEn  <= 1'b0;
      deferHigh  <= 1'b0;
      enable     <= 1'b0;
      invert     <= 1'b0;
      trigEn     <= 1'b0;
      edgeSel    <= '0;
      loadReg    <= '0;
      matchReg   <= '0;
      maskBit    <= 1'b0;
    end else if (regWr) begin
      case (regAddr)
        A_MODE: begin
          modeField  <= regWdata[1:0];
          captureSel <= regWdata[2];
          altSel     <= regWdata[3];
          toHigh     <= regWdata[4];
          edgeIrqEn  <= regWdata[5];
          deferHigh  <= regWdata[6];
        end
        A_CTRL: begin
          enable  <= regWdata[0];
          invert  <= regWdata[1];
          trigEn  <= regWdata[2];
          edgeSel <= regWdata[4:3];
        end
        A_LOAD:  loadReg  <= regWdata[CNT_W-1:0];
        A_MATCH: matchReg <= regWdata[CNT_W-1:0];
        A_MASK:  maskBit  <= regWdata[0];
        default: ;
      endcase
    end
  end

  assign pwmSelected = altSel && !captureSel && (modeField == MODE_PERIODIC);

  always_comb begin
    case (edgeSel)
      EDGE_RISE: edgeHit = riseEv;
      EDGE_FALL: edgeHit = fallEv;
      EDGE_BOTH: edgeHit = riseEv || fallEv;
      default:   edgeHit = 1'b0;
    endcase
  end

  // sticky event status, set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusBit <= 1'b0;
    end else if (edgeIrqEn && edgeHit) begin
      statusBit <= 1'b1;
    end else if (regWr && regAddr == A_STAT && regWdata[0]) begin
      statusBit <= 1'b0;
    end
  end

  assign irqOut = statusBit & maskBit;

  always_comb begin
    stb.run      = pwmSelected && enable;
    stb.loadWr   = regWr && (regAddr == A_LOAD);
    stb.keepHigh = deferHigh;
    stb.toHigh   = toHigh;
    stb.invert   = invert;
    stb.trigEn   = trigEn;
  end

  always_comb begin
    rdData = '0;
    case (regAddr)
      A_MODE:  rdData[6:0] = {deferHigh, edgeIrqEn, toHigh, altSel, captureSel, modeField};
      A_CTRL:  rdData[4:0] = {edgeSel, trigEn, invert, enable};
      A_LOAD:  rdData[CNT_W-1:0] = loadReg;
      A_MATCH: rdData[CNT_W-1:0] = matchReg;
      A_MASK:  rdData[0] = maskBit;
      A_STAT:  rdData[0] = statusBit;
      A_COUNT: rdData[CNT_W-1:0] = countVal;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/dcpwm_datapath.sv
module dcpwm_datapath
  import dcpwm_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int LOW_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic [CNT_W-1:0] loadData,
  input  logic [CNT_W-1:0] loadReg,
  input  logic [CNT_W-1:0] matchReg,
  output logic [CNT_W-1:0] countVal,
  output logic             pwmOut,
  output logic             trigOut,
  output logic             riseEv,
  output logic             fallEv
);
  localparam int HIGH_W = CNT_W - LOW_W;

  logic [HIGH_W-1:0] nextHigh;
  logic              atZero, rawLevel, prevOut;

  assign atZero   = (countVal == '0);
  assign nextHigh = stb.keepHigh ? countVal[CNT_W-1:LOW_W] : loadData[CNT_W-1:LOW_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (stb.loadWr) begin
      countVal <= {nextHigh, loadData[LOW_W-1:0]};
    end else if (stb.run) begin
      countVal <= atZero ? loadReg : countVal - 1'b1;
    end
  end

  assign rawLevel = stb.run &&
                    ((matchReg >= loadReg) || (countVal > matchReg) || (stb.toHigh && atZero));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmOut  <= 1'b0;
      prevOut <= 1'b0;
      trigOut <= 1'b0;
    end else begin
      pwmOut  <= rawLevel ^ stb.invert;
      prevOut <= pwmOut;
      trigOut <= stb.run && stb.trigEn && atZero && !stb.loadWr;
    end
  end

  assign riseEv = pwmOut && !prevOut;
  assign fallEv = !pwmOut && prevOut;
endmodule

// File: rtl/dcpwm_top.sv
module dcpwm_top
  import dcpwm_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int LOW_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              pwmOut,
  output logic              trigOut,
  output logic              irqOut
);
  strobeT           stb;
  logic [CNT_W-1:0] countVal, loadReg, matchReg;
  logic             riseEv, fallEv, statusBit, maskBit, edgeIrqEn;

  dcpwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .countVal(countVal), .riseEv(riseEv), .fallEv(fallEv), .rdData(rdData),
    .stb(stb), .loadReg(loadReg), .matchReg(matchReg), .statusBit(statusBit),
    .maskBit(maskBit), .edgeIrqEn(edgeIrqEn), .irqOut(irqOut)
  );

  dcpwm_datapath #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .loadData(regWdata[CNT_W-1:0]),
    .loadReg(loadReg), .matchReg(matchReg), .countVal(countVal),
    .pwmOut(pwmOut), .trigOut(trigOut), .riseEv(riseEv), .fallEv(fallEv)
  );
endmodule

// File: rtl/dcpwm_checker.sv
module dcpwm_checker
  import dcpwm_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input strobeT           stb,
  input logic [CNT_W-1:0] countVal,
  input logic [CNT_W-1:0] loadReg,
  input logic             pwmOut,
  input logic             trigOut,
  input logic             irqOut,
  input logic             statusBit,
  input logic             maskBit,
  input logic             edgeIrqEn
);
  // R2: timeout reloads the full value
  a_r2_count_reload: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && !stb.loadWr && countVal == '0) |=> countVal == $past(loadReg));

  // R2: one step down per running cycle
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && !stb.loadWr && countVal != '0) |=> countVal == $past(countVal) - 1'b1);

  // R1 and R6: idle output shows only the inversion bit
  a_r1_idle_output: assert property (@(posedge clk) disable iff (!rstN)
    !stb.run |=> pwmOut == $past(stb.invert));

  // R8: trigger only when enabled
  a_r8_trig_gated: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> $past(stb.trigEn) && $past(stb.run));

  // R9: status is set only with the edge interrupt enabled
  a_r9_status_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusBit) |-> $past(edgeIrqEn));

  // R10: interrupt pin requires mask and status
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (maskBit && statusBit));
endmodule

bind dcpwm_top dcpwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .countVal(countVal), .loadReg(loadReg),
  .pwmOut(pwmOut), .trigOut(trigOut), .irqOut(irqOut), .statusBit(statusBit),
  .maskBit(maskBit), .edgeIrqEn(edgeIrqEn)
);

// File: tb/dcpwm_top_test.sv
module dcpwm_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] rdData;
  logic        pwmOut, trigOut, irqOut;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  localparam logic [31:0] M_PWM = 32'h0A;

  always #4 clk = ~clk;

  dcpwm_top uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .rdData(rdData), .pwmOut(pwmOut), .trigOut(trigOut), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic cfg(input logic [31:0] mode, input logic [31:0] ctl,
                     input logic [31:0] load, input logic [31:0] match);
    wr(3'd1, 32'd0);
    wr(3'd0, mode);
    wr(3'd2, load);
    wr(3'd3, match);
    wr(3'd1, ctl);
  endtask

  task automatic countHighs(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwmOut) highs++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R11 pwmOut", {31'd0, pwmOut}, 32'd0);
    chk("R11 trigOut", {31'd0, trigOut}, 32'd0);
    chk("R11 irqOut", {31'd0, irqOut}, 32'd0);
    rd(3'd6, d);
    chk("R11 count", d, 32'd0);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    cfg(M_PWM, 32'd0, 32'd2, 32'd0);
    wr(3'd1, 32'd1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(3'd6, d);
    chk("R2 reload after zero", d, 32'd2);
    @(negedge clk);
    rd(3'd6, d);
    chk("R2 step down", d, 32'd1);
  endtask

  task automatic t_duty(input string tag, input logic [31:0] mode, input logic [31:0] ctl,
                        input logic [31:0] match, input int expHigh);
    int h;
    cfg(mode, ctl, 32'd9, match);
    repeat (12) @(negedge clk);
    countHighs(20, h);
    chk(tag, h, expHigh);
  endtask

  task automatic t_trig(input string tag, input logic [31:0] ctl, input int expPulses);
    int p;
    cfg(M_PWM, ctl, 32'd9, 32'd3);
    repeat (12) @(negedge clk);
    p = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (trigOut) p++;
    end
    chk(tag, p, expPulses);
  endtask

  task automatic t_notpwm(input string tag, input logic [31:0] mode);
    int h;
    logic [31:0] c0, c1;
    cfg(mode, 32'd1, 32'd9, 32'd3);
    rd(3'd6, c0);
    countHighs(20, h);
    rd(3'd6, c1);
    chk({tag, " output"}, h, 0);
    chk({tag, " count held"}, c1, c0);
  endtask

  task automatic t_defer;
    logic [31:0] d;
    wr(3'd1, 32'd0);
    wr(3'd0, M_PWM);
    wr(3'd2, 32'h030005);
    rd(3'd6, d);
    chk("R7 full reload", d, 32'h030005);
    wr(3'd0, M_PWM | 32'h40);
    wr(3'd2, 32'h010002);
    rd(3'd6, d);
    chk("R7 upper byte kept", d, 32'h030002);
    wr(3'd0, M_PWM);
    wr(3'd2, 32'h000003);
    wr(3'd0, M_PWM | 32'h40);
    wr(3'd3, 32'd0);
    wr(3'd2, 32'h020004);
    rd(3'd6, d);
    chk("R7 low part loaded", d, 32'h000004);
    wr(3'd1, 32'd1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd(3'd6, d);
    chk("R7 upper byte at timeout", d, 32'h020004);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(3'd4, 32'd1);
    cfg(M_PWM | 32'h20, 32'h01, 32'd9, 32'd3);
    repeat (30) @(negedge clk);
    rd(3'd5, d);
    chk("R9 rising sets status", d, 32'd1);
    chk("R10 irq with mask", {31'd0, irqOut}, 32'd1);
    wr(3'd4, 32'd0);
    chk("R10 irq masked", {31'd0, irqOut}, 32'd0);
    wr(3'd1, 32'd0);
    repeat (3) @(negedge clk);
    wr(3'd5, 32'd1);
    rd(3'd5, d);
    chk("R10 write one clears", d, 32'd0);
    cfg(M_PWM | 32'h20, 32'h11, 32'd9, 32'd3);
    repeat (30) @(negedge clk);
    rd(3'd5, d);
    chk("R9 code 2 sets nothing", d, 32'd0);
    cfg(M_PWM, 32'h19, 32'd9, 32'd3);
    repeat (30) @(negedge clk);
    rd(3'd5, d);
    chk("R9 enable off", d, 32'd0);
    cfg(M_PWM | 32'h20, 32'h09, 32'd9, 32'd3);
    repeat (30) @(negedge clk);
    rd(3'd5, d);
    chk("R9 falling sets status", d, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_wrap();
    t_duty("R3 duty 6 of 10", M_PWM, 32'd1, 32'd3, 12);
    t_duty("R4 compare zero", M_PWM, 32'd1, 32'd0, 18);
    t_duty("R4 compare equal to reload", M_PWM, 32'd1, 32'd9, 20);
    t_duty("R4 compare above reload", M_PWM, 32'd1, 32'd20, 20);
    t_duty("R5 high at timeout", M_PWM | 32'h10, 32'd1, 32'd0, 20);
    t_duty("R6 inverted", M_PWM, 32'd3, 32'd3, 8);
    t_trig("R8 trigger enabled", 32'd5, 3);
    t_trig("R8 trigger disabled", 32'd1, 0);
    t_notpwm("R1 alternate bit clear", 32'h02);
    t_notpwm("R1 capture bit set", 32'h0E);
    t_notpwm("R1 one-shot field", 32'h09);
    t_defer();
    t_irq();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule